// File: doc/BRIEF.md
# Serial Path Overhead Insertion Port

This block lets logic outside the transmit framer supply the twelve path overhead bytes of each convergence frame over one serial data line. The block drives the serial clock itself and raises a frame marker while it waits for the first bit of the cycle. It shifts the incoming bits in MSB first and assembles them into bytes in a fixed cyclic order. It hands each finished byte to the framer together with its position index and a one-cycle valid strobe.

An insert-enable input selects where the overhead comes from. When the enable is high, the bytes come from the serial line. When it is low, the block passes the internally generated byte (`int_byte_i`) through at the same point in the sequence, and the serial clock and marker keep running. A change of the enable takes effect only at the start of a new cycle. This way one cycle never mixes bytes from both sources.

The serial clock has a fixed two-state sequence, named `PH_LO` and `PH_HI`. Its transitions are:
- `PH_LO`→`PH_HI` is the sampling edge, where `ser_clk_o` rises and a bit is taken.
- `PH_HI`→`PH_LO` is the idle edge, where nothing is taken.

Every clock cycle follows one of these two transitions. Reset returns the sequence to `PH_LO`.

Top module: `poh_serial_insert`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `ser_clk_o` is 0, `frame_mark_o` is 1 and `poh_valid_o` is 0. The first bit sampled after reset is the MSB of index 0.
- R2: `ser_clk_o` alternates low and high, one `clk` cycle each, so one bit lasts two cycles. `ser_data_i` is sampled at the `clk` edge on which `ser_clk_o` rises.
- R3: `frame_mark_o` is 1 for exactly the bit period whose rising `ser_clk_o` edge samples the MSB of index 0. It is 0 for the other 95 bit periods of the cycle.
- R4: With the external source active, each output byte holds the eight sampled bits, the first sampled bit in bit 7 and the last in bit 0.
- R5: The byte indices run through a fixed order with no gaps: 0=Z6, 1=Z5, 2=Z4, 3=Z3, 4=Z2, 5=Z1, 6=spare, 7=B1, 8=G1, 9=spare, 10=spare, 11=C1. After index 11, the next bit sampled is the MSB of index 0.
- R6: `poh_valid_o` is 1 for one cycle, the `ser_clk_o` high phase after the last bit of a byte is sampled. During that cycle `poh_byte_o` and `poh_idx_o` hold that byte and its index.
- R7: With the internal source active, `poh_byte_o` equals `int_byte_i` as sampled on the byte's final sampling edge, and `ser_data_i` has no effect on the output.
- R8: The source selection is taken from `ins_en_i` only on the edge that samples the MSB of index 0. A change at any other time affects nothing before the next cycle.
- R9: `poh_valid_o` is 0 in every cycle other than those named in R6, and is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_en_i | input | 1 | 1 = overhead from serial line, 0 = internal bytes |
| ser_data_i | input | 1 | Serial overhead data, MSB first |
| int_byte_i | input | 8 | Internally generated byte for the current index |
| ser_clk_o | output | 1 | Serial clock driven to the external source |
| frame_mark_o | output | 1 | High during the bit period of the Z6 MSB |
| poh_byte_o | output | 8 | Assembled overhead byte |
| poh_idx_o | output | 4 | Index of the byte on `poh_byte_o` |
| poh_valid_o | output | 1 | One-cycle strobe for a new byte |

## Verification
The hardest situation to reach from the ports is an enable change in the middle of a cycle, which must leave the rest of that cycle on the old source. The stimulus table gives each cycle a source and flips `ins_en_i` halfway through the previous cycle. The bench then expects every remaining byte of that cycle to follow the old source, and the whole next cycle to follow the new one. While the internal source is active, the serial line keeps carrying a different, nonzero pattern. This makes any leak of serial data into the internal path visible in the byte values.

// File: rtl/poh_ins_pkg.sv
package poh_ins_pkg;
    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } sclk_phase_e;
endpackage

// File: rtl/poh_sclk_fsm.sv
module poh_sclk_fsm
    import poh_ins_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic sclk_o,
    output logic sample_o
);
    sclk_phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        sclk_o   = 1'b0;
        sample_o = 1'b0;
        unique case (state_q)
            PH_LO: begin
                state_d  = PH_HI;
                sample_o = 1'b1;
            end
            PH_HI: begin
                state_d  = PH_LO;
                sclk_o   = 1'b1;
            end
        endcase
    end

    // R2
    sclk_rise_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> sclk_o);
    // R2
    sclk_falls_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |=> !sclk_o);
endmodule

// File: rtl/poh_seq_cnt.sv
module poh_seq_cnt #(
    parameter  int N_BYTES = 12,
    parameter  int BYTE_W  = 8,
    localparam int IDX_W   = $clog2(N_BYTES),
    localparam int BIT_W   = $clog2(BYTE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_bit_o,
    output logic             first_bit_o
);
    localparam logic [BIT_W-1:0] TOP_BIT  = BIT_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BYTES - 1);

    logic [BIT_W-1:0] bit_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= TOP_BIT;
            idx_q <= '0;
        end else if (sample_i) begin
            if (bit_q == '0) begin
                bit_q <= TOP_BIT;
                idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
            end else begin
                bit_q <= bit_q - BIT_W'(1);
            end
        end
    end

    assign idx_o       = idx_q;
    assign last_bit_o  = (bit_q == '0);
    assign first_bit_o = (bit_q == TOP_BIT) && (idx_q == '0);

    // R5
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_IDX);
    // R5
    wrap_to_z6_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && last_bit_o && idx_q == LAST_IDX) |=> first_bit_o);
    // R3
    mark_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && first_bit_o) |=> !first_bit_o);
endmodule

// File: rtl/poh_byte_asm.sv
module poh_byte_asm #(
    parameter  int N_BYTES = 12,
    parameter  int BYTE_W  = 8,
    localparam int IDX_W   = $clog2(N_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              last_bit_i,
    input  logic              first_bit_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              ser_i,
    input  logic              ins_en_i,
    input  logic [BYTE_W-1:0] int_byte_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              valid_o
);
    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] shifted;
    logic              ext_q;

    assign shifted = {shreg_q[BYTE_W-2:0], ser_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            ext_q   <= 1'b0;
            byte_o  <= '0;
            idx_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= sample_i && last_bit_i;
            if (sample_i) begin
                shreg_q <= shifted;
                if (first_bit_i) ext_q <= ins_en_i;
                if (last_bit_i) begin
                    byte_o <= ext_q ? shifted : int_byte_i;
                    idx_o  <= idx_i;
                end
            end
        end
    end

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_i && first_bit_i) |=> $stable(ext_q));
    // R9
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R6
    valid_holds_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> $stable(byte_o) && $stable(idx_o));
endmodule

// File: rtl/poh_serial_insert.sv
module poh_serial_insert #(
    parameter  int N_BYTES = 12,
    parameter  int BYTE_W  = 8,
    localparam int IDX_W   = $clog2(N_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_en_i,
    input  logic              ser_data_i,
    input  logic [BYTE_W-1:0] int_byte_i,
    output logic              ser_clk_o,
    output logic              frame_mark_o,
    output logic [BYTE_W-1:0] poh_byte_o,
    output logic [IDX_W-1:0]  poh_idx_o,
    output logic              poh_valid_o
);
    logic             sample;
    logic [IDX_W-1:0] cur_idx;
    logic             last_bit;
    logic             first_bit;

    poh_sclk_fsm u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_o   (ser_clk_o),
        .sample_o (sample)
    );

    poh_seq_cnt #(.N_BYTES(N_BYTES), .BYTE_W(BYTE_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_i    (sample),
        .idx_o       (cur_idx),
        .last_bit_o  (last_bit),
        .first_bit_o (first_bit)
    );

    poh_byte_asm #(.N_BYTES(N_BYTES), .BYTE_W(BYTE_W)) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_i    (sample),
        .last_bit_i  (last_bit),
        .first_bit_i (first_bit),
        .idx_i       (cur_idx),
        .ser_i       (ser_data_i),
        .ins_en_i    (ins_en_i),
        .int_byte_i  (int_byte_i),
        .byte_o      (poh_byte_o),
        .idx_o       (poh_idx_o),
        .valid_o     (poh_valid_o)
    );

    assign frame_mark_o = first_bit;

    // R6
    valid_in_high_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poh_valid_o |-> ser_clk_o);
    // R3
    mark_with_c1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poh_valid_o && frame_mark_o) |-> (poh_idx_o == IDX_W'(N_BYTES - 1)));
endmodule

// File: tb/poh_serial_insert_bench.sv
`timescale 1ns/1ps
module poh_serial_insert_bench;
    localparam int NB = 12;
    localparam int NV = 6;
    // {source select, seed}
    localparam logic [8:0] VEC [NV] = '{
        {1'b1, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'h5A},
        {1'b1, 8'h00}, {1'b0, 8'hFF}, {1'b1, 8'hFF}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ins_en_i = 1'b0;
    logic       ser_data_i = 1'b0;
    logic [7:0] int_byte_i = '0;
    logic       ser_clk_o, frame_mark_o, poh_valid_o;
    logic [7:0] poh_byte_o;
    logic [3:0] poh_idx_o;

    int  vec_n = 0;
    int  err_n = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    poh_serial_insert u_poh_serial_insert (
        .clk(clk), .rst_n(rst_n), .ins_en_i(ins_en_i), .ser_data_i(ser_data_i),
        .int_byte_i(int_byte_i), .ser_clk_o(ser_clk_o), .frame_mark_o(frame_mark_o),
        .poh_byte_o(poh_byte_o), .poh_idx_o(poh_idx_o), .poh_valid_o(poh_valid_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec_n++;
        if (!ok) begin
            err_n++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ext_val(input logic [7:0] seed, input int k);
        return seed + 8'(k * 37);
    endfunction

    function automatic logic [7:0] int_val(input logic [7:0] seed, input int k);
        return seed ^ 8'hC3 ^ 8'(k);
    endfunction

    // Entered at a negedge with ser_clk_o low; leaves at the same point.
    task automatic run_frame(input logic cur_src, input logic [7:0] seed,
                             input logic next_src, input int nbytes);
        for (int k = 0; k < nbytes; k++) begin
            for (int j = 7; j >= 0; j--) begin
                logic [7:0] ev = ext_val(seed, k);
                ser_data_i = ev[j];
                int_byte_i = (j == 0) ? int_val(seed, k) : ~int_val(seed, k);
                chk(ser_clk_o == 1'b0, "R2 low phase", ser_clk_o, 0);
                chk(frame_mark_o == (k == 0 && j == 7), "R3 marker",
                    frame_mark_o, (k == 0 && j == 7));
                @(negedge clk);
                chk(ser_clk_o == 1'b1, "R2 high phase", ser_clk_o, 1);
                if (j == 0) begin
                    chk(poh_valid_o == 1'b1, "R6 valid", poh_valid_o, 1);
                    chk(poh_idx_o == 4'(k), "R5 index", poh_idx_o, k);
                    if (cur_src)
                        chk(poh_byte_o == ev, (k >= 5 && cur_src != next_src) ? "R8 R4 external" : "R4 external",
                            poh_byte_o, ev);
                    else
                        chk(poh_byte_o == int_val(seed, k), (k >= 5 && cur_src != next_src) ? "R8 R7 internal" : "R7 internal",
                            poh_byte_o, int_val(seed, k));
                end else begin
                    chk(poh_valid_o == 1'b0, "R9 no strobe", poh_valid_o, 0);
                end
                if (k == 4 && j == 0) ins_en_i = next_src;
                @(negedge clk);
            end
        end
    endtask

    initial begin
        ins_en_i = VEC[0][8];
        repeat (3) @(negedge clk);
        chk(ser_clk_o == 1'b0 && frame_mark_o == 1'b1 && poh_valid_o == 1'b0,
            "R1 in reset", {ser_clk_o, frame_mark_o, poh_valid_o}, 3'b010);
        rst_n = 1'b1;
        chk(ser_clk_o == 1'b0 && frame_mark_o == 1'b1 && poh_valid_o == 1'b0,
            "R1 after release", {ser_clk_o, frame_mark_o, poh_valid_o}, 3'b010);
        for (int v = 0; v < NV; v++)
            run_frame(VEC[v][8], VEC[v][7:0], VEC[(v + 1) % NV][8], NB);

        // Reset in the middle of a cycle returns to the Z6 MSB.
        run_frame(VEC[0][8], 8'h11, 1'b1, 3);
        rst_n = 1'b0;
        @(negedge clk);
        chk(frame_mark_o == 1'b1 && ser_clk_o == 1'b0, "R1 mid-run reset",
            {frame_mark_o, ser_clk_o}, 2'b10);
        @(negedge clk);
        rst_n = 1'b1;
        chk(poh_valid_o == 1'b0, "R1 no strobe", poh_valid_o, 0);
        run_frame(1'b1, 8'h77, 1'b1, NB);
        // Back-to-back wrap: C1 of this cycle into Z6 of the next.
        run_frame(1'b1, 8'h81, 1'b1, 2);
        chk(poh_idx_o == 4'd1, "R5 wrap", poh_idx_o, 1);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            err_n++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
            $finish;
        end
    end
endmodule